// File: doc/BRIEF.md
# Microcontroller Arithmetic Logic Unit

A purely combinational 16-bit arithmetic logic unit for a small microcontroller core. Each cycle the instruction decoder presents a source operand, a destination operand, the current carry flag, a byte/word select and a 12-bit one-hot-style control word. The unit returns a result, a qualifier telling the register file whether that result is to be stored, and fresh values for the V, N, Z and C status flags, together with the enables that tell the status register which flags to take.

Subtraction, compare and bit-clear are not separate operators. They come from a source inverter placed in front of a single adder or AND path, plus two independent carry-in sources: a constant one and the incoming carry. The same adder also computes relative jump targets when the decoder routes the program counter and a pre-shifted, sign-extended offset into it. Status updates come in two groups. The full group takes every flag from the operation. The reduced group, used by the logical tests and sign extension, forces C to the inverse of Z and clears V.

Top module: `mcu_alu`

## Requirements
- R1: Control word bits are: 0 invert source, 1 add constant one, 2 add incoming carry, 3 select adder, 4 select AND, 5 select OR, 6 select XOR, 7 select decimal add, 8 reduced flag update, 9 full flag update, 10 select single-operand unit, 11 inhibit destination write. The operand called B below is the source, bitwise inverted when bit 0 is set.
- R2: With the adder selected, the result is destination + B + bit1 + (bit2 AND carry in), modulo the operand width, and C is the carry out of the top bit. With no flag update bits set this serves for jump targets (pc + offset).
- R3: With the inverter set, the adder computes destination minus source (with bit 1) or destination minus source minus borrow (with bit 2), and C is set exactly when no borrow occurred.
- R4: Under the adder, V is set when destination and B have equal sign bits and the result sign differs from them. Otherwise V is 0, except as R5 states.
- R5: The AND, OR and XOR selects give destination AND B, OR B and XOR B. For logical and pass results, C is the inverse of Z. Under XOR, V is set when both destination and B are negative.
- R6: With bit 8 set, all four flag enables are 1, C equals NOT Z and V is 0, whatever operation is selected.
- R7: flg_we is 4'b1111 when bit 8 or bit 9 is set, and 4'b0000 otherwise.
- R8: res_we is the inverse of control bit 11.
- R9: With byte_mode high, the result holds bits 7:0 with bits 15:8 zero. N and Z look at bit 7 and the low byte, and the carry is taken out of bit 7. SWAP and SXT results are not masked.
- R10: Decimal add treats each nibble as a BCD digit and chains a carry that starts as (bit2 AND carry in). A digit sum above 9 gets 6 added and produces a carry. C is the final digit carry and V is 0.
- R11: The single-operand unit is selected by unary_sel. 0 rotates right through carry, 1 shifts right arithmetically. Both move bit 0 of B into C and clear V.
- R12: unary_sel 2 swaps the two bytes of B. unary_sel 3 sign-extends bit 7 of B into bits 15:8.
- R13: With no operation select set, the result is B.
- R14: When several selects are set, the priority is decimal add, then adder, AND, OR, XOR, single-operand unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand or program counter |
| cin | input | 1 | Current carry flag |
| byte_mode | input | 1 | 1 selects 8-bit operation |
| ctrl | input | 12 | Control word, bit layout in R1 |
| unary_sel | input | 2 | Single-operand function select |
| res | output | 16 | Result |
| res_we | output | 1 | Result may be written to destination |
| flg | output | 4 | New flags {V, N, Z, C} |
| flg_we | output | 4 | Per-flag update enables, same order |

## Verification
The bench goes after the carry and borrow sense of subtraction. If the inverter and the constant-one carry were not combined, 5 minus 3 would come out as 1 or with C clear. It also probes signed overflow at 0x7FFF+1, byte-mode carry out of bit 7 with a non-zero upper byte, and BCD digit adjust across a chain of 9s. A wrong digit adjust would leave 0x019A instead of 0x0200 or lose the final carry. Other targets are rotate and arithmetic-shift carry capture, the unmasked swap and sign-extend paths, and the reduced flag group's C = NOT Z. Write inhibit on compare and bit-test, select precedence, and a large constrained-random run against a bench reference model cover the rest.

// File: rtl/mcu_alu.sv
`timescale 1ns/1ps
module mcu_alu (
  input  logic [15:0] src,
  input  logic [15:0] dst,
  input  logic        cin,
  input  logic        byte_mode,
  input  logic [11:0] ctrl,
  input  logic [1:0]  unary_sel,
  output logic [15:0] res,
  output logic        res_we,
  output logic [3:0]  flg,
  output logic [3:0]  flg_we
);
  localparam int K_INV = 0, K_INC1 = 1, K_INCC = 2, K_ADD = 3, K_AND = 4, K_OR = 5;
  localparam int K_XOR = 6, K_DADD = 7, K_NZC = 8, K_ALL = 9, K_UNARY = 10, K_NOWR = 11;
  localparam int W = 16, NIB = W / 4;

  logic [W-1:0] opb;
  logic [1:0]   ci;
  logic [W:0]   sum_w;
  logic [8:0]   sum_b;
  logic [W-1:0] bcd, shv, raw;
  logic         bcd_c7, bcd_c15;
  logic         s_dadd, s_add, s_log, s_xor, s_sh, rot, keep_hi, nzc;
  logic         n_f, z_f, c_f, v_f, sd, so, sr;

  assign opb   = ctrl[K_INV] ? ~src : src;
  assign ci    = {1'b0, ctrl[K_INC1]} + {1'b0, ctrl[K_INCC] & cin};
  assign sum_w = {1'b0, dst} + {1'b0, opb} + {{(W-1){1'b0}}, ci};
  assign sum_b = {1'b0, dst[7:0]} + {1'b0, opb[7:0]} + {7'd0, ci};

  always_comb begin
    logic       c;
    logic [4:0] t;
    c = ctrl[K_INCC] & cin;
    bcd = '0;
    bcd_c7 = 1'b0;
    for (int i = 0; i < NIB; i++) begin
      t = {1'b0, dst[4*i +: 4]} + {1'b0, opb[4*i +: 4]} + {4'd0, c};
      if (t > 5'd9) begin
        t = t + 5'd6;
        c = 1'b1;
      end else begin
        c = 1'b0;
      end
      bcd[4*i +: 4] = t[3:0];
      if (i == 1) bcd_c7 = c;
    end
    bcd_c15 = c;
  end

  always_comb begin
    case (unary_sel)
      2'd0:    shv = byte_mode ? {8'h00, cin, opb[7:1]} : {cin, opb[15:1]};
      2'd1:    shv = byte_mode ? {8'h00, opb[7], opb[7:1]} : {opb[15], opb[15:1]};
      2'd2:    shv = {opb[7:0], opb[15:8]};
      default: shv = {{8{opb[7]}}, opb[7:0]};
    endcase
  end

  assign s_dadd  = ctrl[K_DADD];
  assign s_add   = ~s_dadd & ctrl[K_ADD];
  assign s_log   = ~s_dadd & ~ctrl[K_ADD] & (ctrl[K_AND] | ctrl[K_OR] | ctrl[K_XOR]);
  assign s_xor   = s_log & ~ctrl[K_AND] & ~ctrl[K_OR];
  assign s_sh    = ~s_dadd & ~ctrl[K_ADD] & ~s_log & ctrl[K_UNARY];
  assign rot     = s_sh & ~unary_sel[1];
  assign keep_hi = s_sh & unary_sel[1];
  assign nzc     = ctrl[K_NZC];

  always_comb begin
    if (s_dadd)             raw = bcd;
    else if (s_add)         raw = sum_w[W-1:0];
    else if (ctrl[K_AND])   raw = dst & opb;
    else if (ctrl[K_OR])    raw = dst | opb;
    else if (ctrl[K_XOR])   raw = dst ^ opb;
    else if (ctrl[K_UNARY]) raw = shv;
    else                    raw = opb;
  end

  assign res = (byte_mode & ~keep_hi) ? {8'h00, raw[7:0]} : raw;

  assign n_f = byte_mode ? res[7] : res[15];
  assign z_f = byte_mode ? (res[7:0] == 8'h00) : (res == 16'h0000);
  assign sd  = byte_mode ? dst[7] : dst[15];
  assign so  = byte_mode ? opb[7] : opb[15];
  assign sr  = n_f;

  always_comb begin
    if (nzc)         c_f = ~z_f;
    else if (s_dadd) c_f = byte_mode ? bcd_c7 : bcd_c15;
    else if (s_add)  c_f = byte_mode ? sum_b[8] : sum_w[W];
    else if (rot)    c_f = opb[0];
    else             c_f = ~z_f;
  end

  assign v_f    = nzc ? 1'b0 : s_add ? ((sd == so) & (sr != sd)) : s_xor ? (sd & so) : 1'b0;
  assign flg    = {v_f, n_f, z_f, c_f};
  assign flg_we = {4{ctrl[K_NZC] | ctrl[K_ALL]}};
  assign res_we = ~ctrl[K_NOWR];

  always_comb begin
    logic bcd_in_ok, bcd_out_ok;
    bcd_in_ok  = 1'b1;
    bcd_out_ok = 1'b1;
    for (int i = 0; i < NIB; i++) begin
      if (dst[4*i +: 4] > 4'd9 || opb[4*i +: 4] > 4'd9) bcd_in_ok = 1'b0;
      if (res[4*i +: 4] > 4'd9) bcd_out_ok = 1'b0;
    end
    p_reduced_c_r6: assert (!nzc || (flg[0] == ~flg[1]))
      else $error("reduced flag group C is not NOT Z");
    p_sub_carry_r3: assert (!(s_add && !nzc && !byte_mode && ctrl[K_INV] && ctrl[K_INC1] && !ctrl[K_INCC])
                            || (flg[0] == (dst >= src)))
      else $error("subtract carry does not match no-borrow");
    p_bcd_digits_r10: assert (!(s_dadd && !byte_mode && bcd_in_ok) || bcd_out_ok)
      else $error("decimal add produced a non-BCD digit");
    p_sxt_ext_r12: assert (!(s_sh && unary_sel == 2'd3) || (res[15:8] == {8{res[7]}}))
      else $error("sign extension upper byte wrong");
    p_byte_hi_r9: assert (!(byte_mode && !(s_sh && unary_sel[1])) || (res[15:8] == 8'h00))
      else $error("byte mode upper byte not cleared");
  end
endmodule

// File: tb/sim_mcu_alu.sv
`timescale 1ns/1ps
module sim_mcu_alu;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] src, dst;
  logic        cin, byte_mode;
  logic [11:0] ctrl;
  logic [1:0]  unary_sel;
  logic [15:0] res;
  logic        res_we;
  logic [3:0]  flg, flg_we;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  mcu_alu u0 (.src(src), .dst(dst), .cin(cin), .byte_mode(byte_mode), .ctrl(ctrl),
              .unary_sel(unary_sel), .res(res), .res_we(res_we), .flg(flg), .flg_we(flg_we));

  localparam logic [11:0] INV = 12'h001, INC1 = 12'h002, INCC = 12'h004, ADDS = 12'h008;
  localparam logic [11:0] ANDS = 12'h010, ORS = 12'h020, XORS = 12'h040, DADS = 12'h080;
  localparam logic [11:0] NZC = 12'h100, ALL = 12'h200, UNA = 12'h400, NOWR = 12'h800;

  function automatic logic [24:0] model(input logic [15:0] s, input logic [15:0] d, input logic c,
                                        input logic bw, input logic [11:0] k, input logic [1:0] us);
    int w, m, b, dd, r, sum, cc, t, cy, vv, n, z, sd, sb;
    logic [15:0] ob;
    bit keep;
    ob = k[0] ? ~s : s;
    w = bw ? 8 : 16;
    m = (1 << w) - 1;
    b = ob; dd = d;
    keep = 0; cy = -1; vv = 0;
    if (k[7]) begin
      cc = k[2] & c; r = 0;
      for (int i = 0; i < 4; i++) begin
        t = ((dd >> (4*i)) & 15) + ((b >> (4*i)) & 15) + cc;
        if (t > 9) begin t = t + 6; cc = 1; end else cc = 0;
        r = r | ((t & 15) << (4*i));
        if (i == 1 && bw) cy = cc;
      end
      if (!bw) cy = cc;
    end else if (k[3]) begin
      sum = (dd & m) + (b & m) + k[1] + (k[2] & c);
      r = sum & m;
      cy = (sum >> w) & 1;
      sd = (dd >> (w-1)) & 1; sb = (b >> (w-1)) & 1;
      vv = (sd == sb && (((r >> (w-1)) & 1) != sd)) ? 1 : 0;
    end else if (k[4]) r = dd & b;
    else if (k[5]) r = dd | b;
    else if (k[6]) begin
      r = dd ^ b;
      vv = ((dd >> (w-1)) & 1) & ((b >> (w-1)) & 1);
    end else if (k[10]) begin
      case (us)
        2'd0: begin r = bw ? ((c << 7) | ((b & 255) >> 1)) : ((c << 15) | (b >> 1)); cy = b & 1; end
        2'd1: begin r = bw ? ((b & 128) | ((b & 255) >> 1)) : ((b & 32768) | (b >> 1)); cy = b & 1; end
        2'd2: begin r = ((b & 255) << 8) | ((b >> 8) & 255); keep = 1; end
        default: begin r = (b & 128) ? (32'hFF00 | (b & 255)) : (b & 255); keep = 1; end
      endcase
    end else r = b;
    r = r & 32'hFFFF;
    if (bw && !keep) r = r & 255;
    n = (r >> (w-1)) & 1;
    z = ((r & m) == 0) ? 1 : 0;
    if (k[8]) begin cy = 1 - z; vv = 0; end
    else if (cy < 0) cy = 1 - z;
    return {((k[8] | k[9]) ? 4'hF : 4'h0), vv[0], n[0], z[0], cy[0], ~k[11], r[15:0]};
  endfunction

  task automatic apply(input logic [15:0] s, input logic [15:0] d, input logic c, input logic bw,
                       input logic [11:0] k, input logic [1:0] us);
    @(posedge clk);
    src = s; dst = d; cin = c; byte_mode = bw; ctrl = k; unary_sel = us;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [24:0] exp);
    logic [24:0] act;
    act = {flg_we, flg, res_we, res};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual fwe=%h flg=%b we=%b res=%h expected fwe=%h flg=%b we=%b res=%h",
               tag, act[24:21], act[20:17], act[16], act[15:0], exp[24:21], exp[20:17], exp[16], exp[15:0]);
    end
  endtask

  task automatic dir(input string tag, input logic [15:0] s, input logic [15:0] d, input logic c,
                     input logic bw, input logic [11:0] k, input logic [1:0] us,
                     input logic [15:0] er, input logic ew, input logic [3:0] ef, input logic [3:0] efw);
    apply(s, d, c, bw, k, us);
    chk(tag, {efw, ef, ew, er});
  endtask

  function automatic logic [13:0] pick_op(input int idx);
    case (idx)
      0:  return {ADDS | ALL, 2'd0};
      1:  return {ADDS | INCC | ALL, 2'd0};
      2:  return {INV | INC1 | ADDS | ALL, 2'd0};
      3:  return {INV | INCC | ADDS | ALL, 2'd0};
      4:  return {INV | INC1 | ADDS | ALL | NOWR, 2'd0};
      5:  return {DADS | INCC | ALL, 2'd0};
      6:  return {ANDS | NZC, 2'd0};
      7:  return {ANDS | NZC | NOWR, 2'd0};
      8:  return {INV | ANDS, 2'd0};
      9:  return {ORS, 2'd0};
      10: return {XORS | ALL, 2'd0};
      11: return {UNA | ALL, 2'd0};
      12: return {UNA | ALL, 2'd1};
      13: return {UNA, 2'd2};
      14: return {UNA | NZC, 2'd3};
      default: return {12'h000, 2'd0};
    endcase
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual expired expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [13:0] op;
    logic [15:0] rs, rd;
    src = '0; dst = '0; cin = 0; byte_mode = 0; ctrl = '0; unary_sel = '0;
    void'($urandom(32'd24681));
    repeat (3) @(posedge clk);

    dir("R13 idle pass", 16'h0000, 16'h0000, 0, 0, 12'h000, 2'd0, 16'h0000, 1, 4'b0010, 4'h0);
    dir("R3 sub 5-3", 16'h0003, 16'h0005, 0, 0, INV|INC1|ADDS|ALL, 2'd0, 16'h0002, 1, 4'b0001, 4'hF);
    dir("R3 sub 3-5", 16'h0005, 16'h0003, 0, 0, INV|INC1|ADDS|ALL, 2'd0, 16'hFFFE, 1, 4'b0100, 4'hF);
    dir("R3 subc", 16'h0003, 16'h0005, 0, 0, INV|INCC|ADDS|ALL, 2'd0, 16'h0001, 1, 4'b0001, 4'hF);
    dir("R4 overflow", 16'h0001, 16'h7FFF, 0, 0, ADDS|ALL, 2'd0, 16'h8000, 1, 4'b1100, 4'hF);
    dir("R2 addc", 16'h0000, 16'hFFFF, 1, 0, ADDS|INCC|ALL, 2'd0, 16'h0000, 1, 4'b0011, 4'hF);
    dir("R2 jump", 16'hFFFC, 16'h1000, 0, 0, ADDS, 2'd0, 16'h0FFC, 1, 4'b0001, 4'h0);
    dir("R9 byte add", 16'h3401, 16'h12FF, 0, 1, ADDS|ALL, 2'd0, 16'h0000, 1, 4'b0011, 4'hF);
    dir("R10 dadd 199+1", 16'h0001, 16'h0199, 0, 0, DADS|INCC|ALL, 2'd0, 16'h0200, 1, 4'b0000, 4'hF);
    dir("R10 dadd 9999+1", 16'h0001, 16'h9999, 0, 0, DADS|INCC|ALL, 2'd0, 16'h0000, 1, 4'b0011, 4'hF);
    dir("R10 dadd byte", 16'h0054, 16'h0045, 1, 1, DADS|INCC|ALL, 2'd0, 16'h0000, 1, 4'b0011, 4'hF);
    dir("R11 rrc", 16'h0002, 16'h0000, 1, 0, UNA|ALL, 2'd0, 16'h8001, 1, 4'b0100, 4'hF);
    dir("R11 rra", 16'h8001, 16'h0000, 0, 0, UNA|ALL, 2'd1, 16'hC000, 1, 4'b0101, 4'hF);
    dir("R12 swap byte mode", 16'h1234, 16'h0000, 0, 1, UNA, 2'd2, 16'h3412, 1, 4'b0001, 4'h0);
    dir("R12 sxt", 16'h0080, 16'h0000, 0, 0, UNA|NZC, 2'd3, 16'hFF80, 1, 4'b0101, 4'hF);
    dir("R8 cmp", 16'h0005, 16'h0005, 0, 0, INV|INC1|ADDS|ALL|NOWR, 2'd0, 16'h0000, 0, 4'b0011, 4'hF);
    dir("R6 bit test", 16'h0F0F, 16'h00F0, 0, 0, ANDS|NZC|NOWR, 2'd0, 16'h0000, 0, 4'b0010, 4'hF);
    dir("R7 bis no flags", 16'h000F, 16'h00F0, 0, 0, ORS, 2'd0, 16'h00FF, 1, 4'b0001, 4'h0);
    dir("R5 bic", 16'h000F, 16'h00FF, 0, 0, INV|ANDS, 2'd0, 16'h00F0, 1, 4'b0001, 4'h0);
    dir("R5 xor", 16'h8001, 16'h8000, 0, 0, XORS|ALL, 2'd0, 16'h0001, 1, 4'b1001, 4'hF);
    dir("R14 priority", 16'h0001, 16'h0009, 0, 0, DADS|ADDS|ANDS, 2'd0, 16'h0010, 1, 4'b0000, 4'h0);

    for (int k = 0; k < 4000; k++) begin
      rs = 16'($urandom);
      rd = 16'($urandom);
      if (($urandom % 4) == 0) op = {12'($urandom), 2'($urandom)};
      else op = pick_op($urandom % 16);
      apply(rs, rd, 1'($urandom), 1'($urandom), op[13:2], op[1:0]);
      chk("R1 random", model(rs, rd, cin, byte_mode, op[13:2], op[1:0]));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule